// File: doc/BRIEF.md
# Branch Condition and Target Unit

This unit decides whether a conditional branch is taken and produces the address of the next instruction. It serves three ways of testing a condition. In the first, a branch reads a set of status flags. Those flags are updated as a side effect of arithmetic, compare, test and shift operations. In the second, a compare operation produces a 0/1 word that is written to a general register, and a later branch tests that register against zero. In the third, one branch compares two source registers directly and never touches the flags.

The operation side carries a strobe, an operation kind, a condition and two operands. The unit keeps the N, Z, C and V flags in a register. It also returns the 0/1 word for set-style compares. The branch side carries a strobe, the branch style, the condition, the branch PC, a signed instruction offset and two register values. The taken decision and the next PC are combinational. The next PC is PC+4 on fall-through. On a taken branch it is PC+4 plus the sign-extended offset scaled by four. A parameter selects whether shifts update the carry flag.

Top module: `branch_cond_unit`

## Requirements
- R1: After reset all four flags (N, Z, C, V) are clear. A flag-style branch therefore sees EQ false, NE true, GE true and GEU false.
- R2: On an ADD (kind 1), SUB (kind 2) or CMP (kind 3) strobe, the flags take N and Z from the result, C as the carry out, and V as signed overflow. For subtraction and compare, C is NOT borrow.
- R3: On a TEST strobe (kind 4), N and Z are taken from op_a AND op_b, and C and V keep their previous values.
- R4: On SHL (kind 5) and SHR (kind 6), the shift amount is op_b[4:0] and N and Z follow the logically shifted result. V is kept. C becomes the last bit shifted out when the amount is non-zero, and C is kept when the amount is zero. With SHIFT_CARRY=0, shifts never change C.
- R5: PASS (kind 0), SET (kind 7) and any cycle with op_valid low leave all flags unchanged.
- R6: The condition codes are 0 EQ, 1 NE, 2 LT, 3 GE, 4 GT and 5 LE, all signed. LT means N differs from V. GT means Z clear and N equal to V.
- R7: A flag-style branch (br_type 0) tests the registered flags. When a flag update and a branch occur in the same cycle, the branch uses the flags from before the update.
- R8: A SET strobe drives set_val to 1 when op_a compared to op_b meets op_cond, and to 0 otherwise. A register-style branch (br_type 1) evaluates br_cond on br_rs against zero.
- R9: A compare-and-branch (br_type 2) evaluates br_cond on br_rs against br_rt and leaves the flags unchanged.
- R10: When taken, next_pc = br_pc + 4 + sign_extend(br_off)*4. Otherwise next_pc = br_pc + 4. br_taken is low when br_valid is low or br_type is 3.
- R11: Condition 6 (LTU) holds when C is clear, and condition 7 (GEU) holds when C is set. For register and direct styles, C is the NOT-borrow of the subtraction, so these conditions act as unsigned compares.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe |
| op_kind | input | 3 | Operation kind (encoding in R2 to R5) |
| op_cond | input | 3 | Condition used by SET |
| op_a | input | W | First operand |
| op_b | input | W | Second operand or shift amount |
| set_val | output | W | 0/1 result of a SET compare |
| br_valid | input | 1 | Branch strobe |
| br_type | input | 2 | 0 flags, 1 register vs zero, 2 compare two registers, 3 reserved |
| br_cond | input | 3 | Branch condition |
| br_pc | input | W | Address of the branch |
| br_off | input | OFF_W | Signed offset in instructions |
| br_rs | input | W | First source register value |
| br_rt | input | W | Second source register value |
| br_taken | output | 1 | Branch taken |
| next_pc | output | W | Address of the next instruction |

## Verification
The hardest situation to create is a flag update and a flag-style branch in the same cycle. The stimulus raises both strobes together in one low clock phase. It samples the decision before the edge, when the old flags must apply, and again after the edge, when the new flags apply. The carry flag has no port of its own. Every check on carry behaviour for add, subtract, test and shifts is therefore made through the LTU and GEU conditions of a flag-style branch. The bench uses a second instance with shift carry disabled for the same reason.

// File: rtl/branch_cond_unit.sv
module branch_cond_unit #(
  parameter int W = 32,
  parameter int OFF_W = 8,
  parameter bit SHIFT_CARRY = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [2:0]       op_kind,
  input  logic [2:0]       op_cond,
  input  logic [W-1:0]     op_a,
  input  logic [W-1:0]     op_b,
  output logic [W-1:0]     set_val,
  input  logic             br_valid,
  input  logic [1:0]       br_type,
  input  logic [2:0]       br_cond,
  input  logic [W-1:0]     br_pc,
  input  logic [OFF_W-1:0] br_off,
  input  logic [W-1:0]     br_rs,
  input  logic [W-1:0]     br_rt,
  output logic             br_taken,
  output logic [W-1:0]     next_pc
);
  localparam int SH_W = $clog2(W);
  localparam logic [2:0] K_ADD = 3'd1, K_SUB = 3'd2, K_CMP = 3'd3, K_TEST = 3'd4,
                         K_SHL = 3'd5, K_SHR = 3'd6, K_SET = 3'd7;
  localparam logic [1:0] T_FLAG = 2'd0, T_REG = 2'd1, T_DIR = 2'd2;

  typedef struct packed {logic n; logic z; logic c; logic v;} flags_t;

  function automatic flags_t sub_flags(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] d;
    flags_t f;
    d = {1'b0, a} - {1'b0, b};
    f.n = d[W-1];
    f.z = (d[W-1:0] == '0);
    f.c = ~d[W];
    f.v = (a[W-1] != b[W-1]) && (d[W-1] != a[W-1]);
    return f;
  endfunction

  function automatic logic holds(input flags_t f, input logic [2:0] c);
    case (c)
      3'd0:    return f.z;
      3'd1:    return ~f.z;
      3'd2:    return f.n != f.v;
      3'd3:    return f.n == f.v;
      3'd4:    return ~f.z && (f.n == f.v);
      3'd5:    return f.z || (f.n != f.v);
      3'd6:    return ~f.c;
      default: return f.c;
    endcase
  endfunction

  flags_t flags_q, flags_d, br_f;
  logic [W:0]      sum, shl_ext, shr_ext;
  logic [W-1:0]    and_res, shl_res, shr_res;
  logic [SH_W-1:0] sh;

  assign sh      = op_b[SH_W-1:0];
  assign sum     = {1'b0, op_a} + {1'b0, op_b};
  assign and_res = op_a & op_b;
  assign shl_ext = {1'b0, op_a} << sh;
  assign shr_ext = {op_a, 1'b0} >> sh;
  assign shl_res = shl_ext[W-1:0];
  assign shr_res = shr_ext[W:1];

  always_comb begin
    flags_d = flags_q;
    if (op_valid) begin
      case (op_kind)
        K_ADD: begin
          flags_d.n = sum[W-1];
          flags_d.z = (sum[W-1:0] == '0);
          flags_d.c = sum[W];
          flags_d.v = (op_a[W-1] == op_b[W-1]) && (sum[W-1] != op_a[W-1]);
        end
        K_SUB, K_CMP: flags_d = sub_flags(op_a, op_b);
        K_TEST: begin
          flags_d.n = and_res[W-1];
          flags_d.z = (and_res == '0);
        end
        K_SHL: begin
          flags_d.n = shl_res[W-1];
          flags_d.z = (shl_res == '0);
          if (SHIFT_CARRY && sh != '0) flags_d.c = shl_ext[W];
        end
        K_SHR: begin
          flags_d.n = shr_res[W-1];
          flags_d.z = (shr_res == '0);
          if (SHIFT_CARRY && sh != '0) flags_d.c = shr_ext[0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign set_val = {{(W-1){1'b0}},
                    op_valid && (op_kind == K_SET) && holds(sub_flags(op_a, op_b), op_cond)};

  always_comb begin
    case (br_type)
      T_FLAG:  br_f = flags_q;
      T_REG:   br_f = sub_flags(br_rs, '0);
      default: br_f = sub_flags(br_rs, br_rt);
    endcase
  end

  logic [W-1:0] seq_pc, off_ext;
  assign seq_pc   = br_pc + W'(4);
  assign off_ext  = {{(W-OFF_W){br_off[OFF_W-1]}}, br_off};
  assign br_taken = br_valid && (br_type == T_FLAG || br_type == T_REG || br_type == T_DIR)
                    && holds(br_f, br_cond);
  assign next_pc  = br_taken ? seq_pc + (off_ext << 2) : seq_pc;
endmodule

// File: rtl/branch_cond_unit_chk.sv
module branch_cond_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_valid,
  input logic [2:0]   op_kind,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic [W-1:0] set_val,
  input logic         br_valid,
  input logic [W-1:0] br_pc,
  input logic         br_taken,
  input logic [W-1:0] next_pc,
  input logic [3:0]   flags
);
  // R10
  no_strobe_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid |-> !br_taken);
  // R10
  fallthrough_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !br_taken |-> next_pc == br_pc + W'(4));
  // R5
  flags_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid || op_kind == 3'd0 || op_kind == 3'd7) |=> $stable(flags));
  // R2
  equal_sub_zc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_kind == 3'd2 || op_kind == 3'd3) && op_a == op_b) |=> (flags[2] && flags[1]));
  // R8
  set_is_bool_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_val[W-1:1] == '0);
endmodule

bind branch_cond_unit branch_cond_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
  .op_a(op_a), .op_b(op_b), .set_val(set_val), .br_valid(br_valid),
  .br_pc(br_pc), .br_taken(br_taken), .next_pc(next_pc), .flags(flags_q)
);

// File: tb/branch_cond_unit_test.sv
module branch_cond_unit_test;
  logic clk = 0, rst_n = 0;
  logic op_valid = 0, br_valid = 0;
  logic [2:0] op_kind = 0, op_cond = 0, br_cond = 0;
  logic [1:0] br_type = 0;
  logic [31:0] op_a = 0, op_b = 0, br_pc = 0, br_rs = 0, br_rt = 0;
  logic [7:0] br_off = 0;
  logic [31:0] set_val, next_pc, set_nc, pc_nc;
  logic taken, taken_nc;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  branch_cond_unit uut (.clk, .rst_n, .op_valid, .op_kind, .op_cond, .op_a, .op_b,
    .set_val, .br_valid, .br_type, .br_cond, .br_pc, .br_off, .br_rs, .br_rt,
    .br_taken(taken), .next_pc);
  branch_cond_unit #(.SHIFT_CARRY(1'b0)) uut_nc (.clk, .rst_n, .op_valid, .op_kind, .op_cond,
    .op_a, .op_b, .set_val(set_nc), .br_valid, .br_type, .br_cond, .br_pc, .br_off,
    .br_rs, .br_rt, .br_taken(taken_nc), .next_pc(pc_nc));

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_op(logic [2:0] k, logic [31:0] a, logic [31:0] b, logic v = 1);
    @(negedge clk);
    op_kind = k; op_a = a; op_b = b; op_valid = v;
    @(negedge clk);
    op_valid = 0;
  endtask

  task automatic expect_br(string req, logic [1:0] t, logic [2:0] c, logic [31:0] pc,
                           logic [7:0] off, logic [31:0] rs, logic [31:0] rt, logic exp_t);
    logic [31:0] exp_pc;
    br_type = t; br_cond = c; br_pc = pc; br_off = off; br_rs = rs; br_rt = rt; br_valid = 1;
    #1;
    exp_pc = exp_t ? pc + 32'd4 + {{22{off[7]}}, off, 2'b00} : pc + 32'd4;
    chk({req, " taken"}, {31'd0, taken}, {31'd0, exp_t});
    chk({req, " next_pc"}, next_pc, exp_pc);
    br_valid = 0;
  endtask

  task automatic flag_br(string req, logic [2:0] c, logic exp_t);
    expect_br(req, 2'd0, c, 32'h100, 8'd3, 0, 0, exp_t);
  endtask

  task automatic t_reset;
    flag_br("R1 EQ", 3'd0, 0);
    flag_br("R1 NE", 3'd1, 1);
    flag_br("R1 GE", 3'd3, 1);
    flag_br("R1 GEU", 3'd7, 0);
  endtask

  task automatic t_arith;
    do_op(3'd2, 5, 5);
    flag_br("R2 sub eq EQ", 3'd0, 1);
    flag_br("R2 sub eq GEU", 3'd7, 1);
    do_op(3'd3, 3, 5);
    flag_br("R2 cmp lt LT", 3'd2, 1);
    flag_br("R11 cmp borrow LTU", 3'd6, 1);
    do_op(3'd1, 32'h7fffffff, 1);
    flag_br("R2 add ovf LT", 3'd2, 0);
    flag_br("R6 add ovf GE", 3'd3, 1);
    do_op(3'd1, 32'hffffffff, 1);
    flag_br("R2 add carry EQ", 3'd0, 1);
    flag_br("R2 add carry GEU", 3'd7, 1);
  endtask

  task automatic t_test;
    do_op(3'd2, 3, 5);
    do_op(3'd4, 32'hf0, 32'h0f);
    flag_br("R3 test zero EQ", 3'd0, 1);
    flag_br("R3 test keeps C LTU", 3'd6, 1);
    do_op(3'd2, 5, 3);
    do_op(3'd4, 32'h80000000, 32'hffffffff);
    flag_br("R3 test neg LT", 3'd2, 1);
    flag_br("R3 test keeps C GEU", 3'd7, 1);
  endtask

  task automatic t_shift;
    do_op(3'd5, 32'h80000000, 1);
    flag_br("R4 shl out EQ", 3'd0, 1);
    flag_br("R4 shl carry GEU", 3'd7, 1);
    do_op(3'd6, 2, 1);
    flag_br("R4 shr NE", 3'd1, 1);
    flag_br("R4 shr no carry LTU", 3'd6, 1);
    do_op(3'd6, 3, 1);
    flag_br("R4 shr carry GEU", 3'd7, 1);
    do_op(3'd5, 5, 0);
    flag_br("R4 zero amount keeps C", 3'd7, 1);
    do_op(3'd1, 32'h7fffffff, 1);
    do_op(3'd6, 4, 1);
    flag_br("R4 shift keeps V LT", 3'd2, 1);
    do_op(3'd2, 5, 3);
    do_op(3'd5, 1, 1);
    br_type = 0; br_cond = 3'd6; br_pc = 32'h100; br_off = 0; br_valid = 1;
    #1;
    chk("R4 shl clears C", {31'd0, taken}, 32'd1);
    chk("R4 no shift carry keeps C", {31'd0, taken_nc}, 32'd0);
    br_valid = 0;
  endtask

  task automatic t_hold;
    do_op(3'd2, 5, 5);
    do_op(3'd0, 1, 2);
    flag_br("R5 pass keeps Z", 3'd0, 1);
    do_op(3'd7, 1, 2);
    flag_br("R5 set keeps Z", 3'd0, 1);
    do_op(3'd2, 1, 2, 0);
    flag_br("R5 no strobe keeps Z", 3'd0, 1);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    op_kind = 3'd2; op_a = 1; op_b = 2; op_valid = 1;
    br_type = 0; br_cond = 3'd0; br_pc = 32'h200; br_off = 8'd1; br_valid = 1;
    #1;
    chk("R7 old flags before edge", {31'd0, taken}, 32'd1);
    @(posedge clk);
    #1;
    chk("R7 new flags after edge", {31'd0, taken}, 32'd0);
    @(negedge clk);
    op_valid = 0; br_valid = 0;
  endtask

  task automatic set_check(string req, logic [2:0] c, logic [31:0] a, logic [31:0] b, logic [31:0] exp);
    @(negedge clk);
    op_kind = 3'd7; op_cond = c; op_a = a; op_b = b; op_valid = 1;
    #1;
    chk(req, set_val, exp);
    @(negedge clk);
    op_valid = 0;
  endtask

  task automatic t_set_reg;
    set_check("R8 set LT true", 3'd2, 32'hffffffff, 1, 1);
    set_check("R11 set LTU false", 3'd6, 32'hffffffff, 1, 0);
    expect_br("R8 reg NE nonzero", 2'd1, 3'd1, 32'h40, 8'd2, 1, 9, 1);
    expect_br("R8 reg NE zero", 2'd1, 3'd1, 32'h40, 8'd2, 0, 9, 0);
    expect_br("R8 reg LT negative", 2'd1, 3'd2, 32'h40, 8'd2, 32'hfffffffb, 0, 1);
  endtask

  task automatic t_direct;
    do_op(3'd2, 5, 5);
    expect_br("R9 dir EQ", 2'd2, 3'd0, 32'h80, 8'd4, 7, 7, 1);
    expect_br("R9 dir GT signed", 2'd2, 3'd4, 32'h80, 8'd4, 32'hffffffff, 1, 0);
    expect_br("R11 dir GEU", 2'd2, 3'd7, 32'h80, 8'd4, 32'hffffffff, 1, 1);
    expect_br("R6 dir LE equal", 2'd2, 3'd5, 32'h80, 8'd4, 3, 3, 1);
    expect_br("R9 dir NE differ", 2'd2, 3'd1, 32'h80, 8'd4, 1, 2, 1);
    flag_br("R9 flags untouched", 3'd0, 1);
  endtask

  task automatic t_target;
    expect_br("R10 max forward", 2'd1, 3'd1, 32'h1000, 8'h7f, 1, 0, 1);
    chk("R10 forward value", next_pc, 32'h1200);
    br_valid = 1; #1;
    chk("R10 forward value", next_pc, 32'h1200);
    br_valid = 0;
    expect_br("R10 max backward", 2'd1, 3'd1, 32'h1000, 8'h80, 1, 0, 1);
    br_valid = 1; br_off = 8'h80; #1;
    chk("R10 backward value", next_pc, 32'h0e04);
    br_valid = 0; #1;
    chk("R10 no strobe taken", {31'd0, taken}, 32'd0);
    chk("R10 no strobe pc", next_pc, 32'h1004);
    expect_br("R10 reserved type", 2'd3, 3'd1, 32'h1000, 8'h10, 1, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_arith();
    t_test();
    t_shift();
    t_hold();
    t_same_cycle();
    t_set_reg();
    t_direct();
    t_target();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule